// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which of the 32 lanes of a SIMD thread may write back results while that thread runs predicated if/else code, which may be nested. Every lane executes every instruction. The active mask produced here only decides whether a lane commits its result. The mask unit keeps the current active mask and a hardware stack of saved masks, and it reacts to three one-cycle commands:

- **Push**, at a divergent branch: the current mask is saved and narrowed by the per-lane predicate.
- **Complement**, at the else point: the lanes of the enclosing mask that skipped the if-path become active.
- **Pop**, at the convergence point: the saved mask is restored.

Saving the mask on every branch lets each nested if-body and else-body run under a progressively narrower mask. The enclosing mask comes back exactly when the paths reconverge. Misuse of the stack is reported through sticky flags and does not corrupt state. A one-cycle hint tells the sequencer that a push left no lane active, so the if-path may be skipped.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset:
  - `activeMask` is all ones.
  - `skipIf`, `overflow` and `underflow` are 0.
  - The stack holds no entries.
- R2: An accepted push saves the current mask on the stack and makes the new mask `activeMask & pred`. Bit i of every mask and of `pred` belongs to lane i. The new value is visible after the clock edge that samples the command.
- R3: A complement makes the new mask `top & ~activeMask`, where `top` is the most recently saved mask. When the stack is empty, `top` is taken as all ones. The stack depth is unchanged.
- R4: A pop on a non-empty stack makes the most recently saved mask active again and removes it from the stack.
- R5: Nested push/complement/pop sequences restore each enclosing mask in last-in, first-out order.
- R6: A push while the stack holds DEPTH entries leaves both the mask and the stack unchanged. It sets `overflow`, which stays set until reset.
- R7: A pop on an empty stack leaves the mask unchanged. It sets `underflow`, which stays set until reset.
- R8: `skipIf` is 1 for exactly the one cycle after an accepted push whose resulting mask is all zeros. It is 0 in every other cycle.
- R9: When several commands are asserted in the same cycle, push takes priority over complement, and complement over pop. A push that is rejected because the stack is full still blocks the other commands.
- R10: In a cycle with no command, the mask and the stack are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdPush | input | 1 | Divergent-branch command: save the mask and narrow it by `pred` |
| cmdComp | input | 1 | Else-point command: switch to the complementary lanes of the enclosing mask |
| cmdPop | input | 1 | Convergence command: restore the saved mask |
| pred | input | LANES | Per-lane predicate; bit i belongs to lane i |
| activeMask | output | LANES | Lanes allowed to commit results |
| skipIf | output | 1 | One-cycle hint that the last push left no active lane |
| overflow | output | 1 | Sticky: a push arrived while the stack was full |
| underflow | output | 1 | Sticky: a pop arrived while the stack was empty |

## Verification
All four outputs are registered. A command sampled at a rising edge is therefore reflected on `activeMask`, `skipIf` and the flags right after that edge, with no further delay.

The bench drives each command at a falling edge and withdraws it just after the next rising edge, so every command acts for exactly one cycle. It then compares every output with its reference model at the following falling edge, which is one cycle after the command.

Random command mixes, including simultaneous commands, run alongside directed sequences for:
- deep nesting,
- filling the stack to overflow,
- popping an empty stack,
- a push whose predicate leaves no lane active.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  // strobes from control to datapath; at most one is high per cycle
  typedef struct packed {
    logic doPush;
    logic doComp;
    logic doPop;
  } mask_strobe_t;
endpackage

// File: rtl/mask_stack_ctrl.sv
module mask_stack_ctrl
  import simt_mask_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmdPush,
  input  logic          cmdComp,
  input  logic          cmdPop,
  output mask_strobe_t  strb,
  output logic [PW-1:0] depthPtr,
  output logic          overflow,
  output logic          underflow
);
  logic isFull, isEmpty, popSel;

  assign isFull  = (depthPtr == PW'(DEPTH));
  assign isEmpty = (depthPtr == '0);
  // push outranks complement, complement outranks pop
  assign popSel  = !cmdPush && !cmdComp && cmdPop;

  always_comb begin
    strb.doPush = cmdPush && !isFull;
    strb.doComp = !cmdPush && cmdComp;
    strb.doPop  = popSel && !isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depthPtr  <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (strb.doPush)             depthPtr  <= depthPtr + 1'b1;
      else if (strb.doPop)         depthPtr  <= depthPtr - 1'b1;
      if (cmdPush && isFull)       overflow  <= 1'b1;
      if (popSel && isEmpty)       underflow <= 1'b1;
    end
  end

  // R6: overflow is sticky
  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R7: underflow is sticky
  assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R6: a push into a full stack leaves the depth alone
  assert_full_push_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdPush && isFull) |=> $stable(depthPtr));
  // R7: a pop from an empty stack keeps it empty
  assert_empty_pop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (popSel && isEmpty) |=> (depthPtr == '0));
  // R9: strobes stay mutually exclusive
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.doPush, strb.doComp, strb.doPop}));
endmodule

// File: rtl/mask_stack_dp.sv
module mask_stack_dp
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mask_strobe_t     strb,
  input  logic [PW-1:0]    depthPtr,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] activeMask,
  output logic             skipIf
);
  logic [LANES-1:0] saved [DEPTH];
  logic [LANES-1:0] enclosing, narrowed;
  logic [IW-1:0]    wrIdx, rdIdx;

  assign wrIdx     = IW'(depthPtr);
  assign rdIdx     = IW'(depthPtr - 1'b1);
  assign enclosing = (depthPtr == '0) ? '1 : saved[rdIdx];
  assign narrowed  = activeMask & pred;

  always_ff @(posedge clk) begin
    if (strb.doPush) saved[wrIdx] <= activeMask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeMask <= '1;
      skipIf     <= 1'b0;
    end else begin
      skipIf <= strb.doPush && (narrowed == '0);
      if (strb.doPush)      activeMask <= narrowed;
      else if (strb.doComp) activeMask <= enclosing & ~activeMask;
      else if (strb.doPop)  activeMask <= saved[rdIdx];
    end
  end

  // R2: a push never enables a lane that was off
  assert_push_narrows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doPush |=> ((activeMask & ~$past(activeMask)) == '0));
  // R3: the else-path lanes are disjoint from the if-path lanes
  assert_comp_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doComp |=> ((activeMask & $past(activeMask)) == '0));
  // R8: the skip hint only appears with an empty mask
  assert_skip_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    skipIf |-> (activeMask == '0));
  // R10: idle cycles hold the mask
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == '0) |=> $stable(activeMask));
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdPush,
  input  logic             cmdComp,
  input  logic             cmdPop,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] activeMask,
  output logic             skipIf,
  output logic             overflow,
  output logic             underflow
);
  localparam int PW = $clog2(DEPTH + 1);

  mask_strobe_t  strb;
  logic [PW-1:0] depthPtr;

  mask_stack_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmdPush(cmdPush), .cmdComp(cmdComp), .cmdPop(cmdPop),
    .strb(strb), .depthPtr(depthPtr),
    .overflow(overflow), .underflow(underflow)
  );

  mask_stack_dp #(.LANES(LANES), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rst_n(rst_n),
    .strb(strb), .depthPtr(depthPtr), .pred(pred),
    .activeMask(activeMask), .skipIf(skipIf)
  );
endmodule

// File: tb/test_simt_mask_stack.sv
module test_simt_mask_stack;
  localparam int LANES = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdPush = 0, cmdComp = 0, cmdPop = 0;
  logic [LANES-1:0] pred = '0;
  logic [LANES-1:0] activeMask;
  logic skipIf, overflow, underflow;

  int nRun = 0, nFail = 0;
  int cycles = 0;

  // reference model state
  logic [LANES-1:0] mMask;
  logic [LANES-1:0] mStack [DEPTH];
  int mPtr;
  logic mSkip, mOv, mUn;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) i_simt_mask_stack (
    .clk(clk), .rst_n(rst_n), .cmdPush(cmdPush), .cmdComp(cmdComp),
    .cmdPop(cmdPop), .pred(pred), .activeMask(activeMask),
    .skipIf(skipIf), .overflow(overflow), .underflow(underflow));

  always #5 clk = ~clk;

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [LANES-1:0] act,
                     input logic [LANES-1:0] exp);
    nRun = nRun + 1;
    if (act !== exp) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    chk({tag, " mask"}, activeMask, mMask);
    chk({tag, " skipIf"}, {31'd0, skipIf}, {31'd0, mSkip});
    chk({tag, " overflow"}, {31'd0, overflow}, {31'd0, mOv});
    chk({tag, " underflow"}, {31'd0, underflow}, {31'd0, mUn});
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; cmdPush = 0; cmdComp = 0; cmdPop = 0;
    @(negedge clk);
    rst_n = 1'b1;
    mMask = '1; mPtr = 0; mSkip = 0; mOv = 0; mUn = 0;
  endtask

  // model of one command cycle, following R2..R10
  task automatic modelStep(input logic p, input logic c, input logic q,
                           input logic [LANES-1:0] pr);
    logic [LANES-1:0] top;
    mSkip = 1'b0;
    if (p) begin
      if (mPtr == DEPTH) mOv = 1'b1;
      else begin
        mStack[mPtr] = mMask;
        mPtr = mPtr + 1;
        mMask = mMask & pr;
        mSkip = (mMask == '0);
      end
    end else if (c) begin
      top = (mPtr == 0) ? '1 : mStack[mPtr-1];
      mMask = top & ~mMask;
    end else if (q) begin
      if (mPtr == 0) mUn = 1'b1;
      else begin
        mPtr = mPtr - 1;
        mMask = mStack[mPtr];
      end
    end
  endtask

  // drive one command for one cycle, then check one cycle later
  task automatic step(input logic p, input logic c, input logic q,
                      input logic [LANES-1:0] pr, input string tag);
    @(negedge clk);
    cmdPush = p; cmdComp = c; cmdPop = q; pred = pr;
    modelStep(p, c, q, pr);
    @(posedge clk);
    #1;
    cmdPush = 0; cmdComp = 0; cmdPop = 0;
    @(negedge clk);
    chkAll(tag);
  endtask

  initial begin
    logic [LANES-1:0] outer;
    void'($urandom(32'd20240611));
    doReset();
    @(negedge clk);
    chkAll("R1 reset");
    step(0, 0, 1, '0, "R1 empty after reset");   // pop on fresh stack: underflow
    step(0, 0, 1, '0, "R7 underflow sticky");

    // nested if/else: R2, R3, R4, R5
    doReset();
    step(1, 0, 0, 32'h0000_FFFF, "R2 outer push");
    outer = mMask;
    step(1, 0, 0, 32'h00FF_00FF, "R2 inner push");
    step(0, 1, 0, '0, "R3 inner else");
    chk("R3 inner else lanes", activeMask, 32'h0000_FF00);
    step(0, 0, 1, '0, "R4 inner pop");
    chk("R5 outer restored", activeMask, outer);
    step(0, 1, 0, '0, "R3 outer else");
    chk("R3 outer else lanes", activeMask, 32'hFFFF_0000);
    step(0, 0, 1, '0, "R5 back to all");
    step(0, 1, 0, '0, "R3 empty stack complement");
    chk("R3 complement vs all ones", activeMask, 32'h0000_0000);
    step(0, 1, 0, '0, "R3 complement back");
    step(0, 0, 0, '0, "R10 idle");

    // skip hint: R8
    doReset();
    step(1, 0, 0, '0, "R8 zero push");
    chk("R8 skip seen", {31'd0, skipIf}, 32'd1);
    step(0, 0, 0, '0, "R8 skip drops");
    step(1, 0, 0, '1, "R8 push keeps zero");

    // overflow: R6
    doReset();
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, 0, ~(32'h1 << i), "R6 fill");
    step(1, 0, 0, '0, "R6 push on full");
    chk("R6 mask kept", activeMask, 32'hFFFF_FF00);
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 1, '0, "R6 unwind");
    chk("R6 stack intact", activeMask, '1);

    // priority: R9
    doReset();
    step(1, 1, 1, 32'h0F0F_0F0F, "R9 push wins");
    step(0, 1, 1, '0, "R9 comp over pop");
    chk("R9 comp result", activeMask, 32'hF0F0_F0F0);

    // random mix against the model
    doReset();
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [LANES-1:0] pr;
      logic p, c, q;
      string tag;
      sel = int'($urandom_range(0, 99));
      pr  = $urandom();
      if ($urandom_range(0, 9) == 0) pr = '0;
      if ($urandom_range(0, 9) == 0) pr = '1;
      p = (sel < 35); c = (sel >= 35 && sel < 55); q = (sel >= 55 && sel < 85);
      if (sel >= 95) begin p = $urandom_range(0, 1); c = 1; q = 1; end
      if (p) tag = "R2 random push";
      else if (c) tag = "R3 random comp";
      else if (q) tag = "R4 random pop";
      else tag = "R10 random idle";
      if (sel >= 95) tag = "R9 random multi";
      step(p, c, q, pr, tag);
      if (n == 300) doReset();
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule